// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block fetches instructions for a stored-program accumulator machine in which every memory word carries two instructions. It reads a word through an address register and a word buffer register. It sends the left instruction to the execute stage and keeps the right instruction in a one-entry instruction buffer. When the left instruction retires, the right one is issued from that buffer with no memory access. The program counter counts instruction pairs, so it advances by one per word read.

The execute stage sees an opcode and an address field under a valid/ready handshake. When it accepts an instruction, it may also request a jump. The jump names a word address and a half: the left half or the right half. A jump to the left half discards any buffered instruction and reads the target word in full. A jump to the right half reads the target word and issues only its right instruction. Reset is synchronous: it sets the program counter to zero and empties the buffer.

Top module: `pair_fetch_unit`

## Requirements
- R1: While reset is held, neither a read request nor an instruction is presented. After reset, the first read is made at word address 0.
- R2: A memory word is split as follows. Bits [39:20] are the left instruction and bits [19:0] are the right instruction. Within each instruction, the upper 8 bits are the opcode and the lower 12 bits are the address field. After a normal word read, the left instruction is issued first.
- R3: After the left instruction of a fully read word is accepted without a jump, the next instruction issued is that word's right instruction. No memory read takes place before it is issued, and a read is never requested while an instruction is being presented.
- R4: Once both halves of the word at address A are accepted without a jump, the next read is made at address A+1.
- R5: The read request, with its address held constant, stays asserted until the memory returns read-valid.
- R6: A jump to the left half (jump_right=0) makes the next read go to the target address. Any buffered right instruction is discarded. The left and then the right instruction of the target word follow.
- R7: A jump to the right half (jump_right=1) reads the target word and issues only its right instruction. The next read after that is made at target+1.
- R8: While an instruction is presented and not accepted, its opcode and address stay unchanged.
- R9: The first instruction taken from a read word is presented exactly two clock cycles after the cycle in which read-valid completed the read.
- R10: The pair address wraps from 4095 to 0 when reads proceed in sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 12 | Word address of the read, from the address register |
| mem_rdata | input | 40 | Word returned by memory |
| mem_rvalid | input | 1 | Read data valid; completes a pending read |
| issue_valid | output | 1 | An instruction is presented to execute |
| issue_opcode | output | 8 | Opcode of the presented instruction |
| issue_addr | output | 12 | Address field of the presented instruction |
| issue_ready | input | 1 | Execute accepts the presented instruction |
| jump_valid | input | 1 | Taken jump, sampled together with an acceptance |
| jump_target | input | 12 | Word address of the jump target |
| jump_right | input | 1 | 1 selects the right half of the target word, 0 the left half |

## Verification
The assertions take three things for granted about the inputs. The execute stage raises jump_valid only in a cycle where it accepts a presented instruction. The memory raises read-valid only to answer a request that is still pending. A jump target is stable in that same cycle. The stimulus meets all three. Its memory model answers a request after 0 to 2 wait cycles and otherwise holds read-valid low. The execute model withholds ready in some cycles, and it requests jumps only on acceptances. Those jumps go to both halves and include a left-half jump to the last word address, which exercises the wrap.

// File: rtl/pfu_pkg.sv
package pfu_pkg;
  localparam int DEF_OPC_W = 8;
  localparam int DEF_ADR_W = 12;

  typedef enum logic [1:0] {
    S_ADDR   = 2'd0,
    S_READ   = 2'd1,
    S_DECODE = 2'd2,
    S_ISSUE  = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/pfu_pc.sv
module pfu_pc #(
  parameter int ADR_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ADR_W-1:0] load_val,
  input  logic             inc,
  output logic [ADR_W-1:0] pc
);
  function automatic logic [ADR_W-1:0] pair_next(input logic [ADR_W-1:0] cur);
    return cur + ADR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= load_val;
    else if (inc)  pc <= pair_next(pc);
  end
endmodule

// File: rtl/pfu_ibuf.sv
module pfu_ibuf #(
  parameter int INS_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             park,
  input  logic [INS_W-1:0] park_ins,
  input  logic             flush,
  input  logic             take,
  output logic             valid,
  output logic [INS_W-1:0] ins
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      ins   <= '0;
    end else if (flush || take) begin
      valid <= 1'b0;
    end else if (park) begin
      valid <= 1'b1;
      ins   <= park_ins;
    end
  end
endmodule

// File: rtl/pfu_seq.sv
module pfu_seq
  import pfu_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter int ADR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADR_W-1:0]          pc,
  input  logic                      buf_valid,
  input  logic [OPC_W+ADR_W-1:0]    buf_ins,
  input  logic                      mem_rvalid,
  input  logic [2*(OPC_W+ADR_W)-1:0] mem_rdata,
  input  logic                      issue_ready,
  input  logic                      jump_valid,
  input  logic [ADR_W-1:0]          jump_target,
  input  logic                      jump_right,
  output logic                      mem_rd_en,
  output logic [ADR_W-1:0]          mem_addr,
  output logic                      issue_valid,
  output logic [OPC_W-1:0]          issue_opcode,
  output logic [ADR_W-1:0]          issue_addr,
  output logic                      pc_load,
  output logic [ADR_W-1:0]          pc_load_val,
  output logic                      pc_inc,
  output logic                      buf_park,
  output logic [OPC_W+ADR_W-1:0]    buf_park_ins,
  output logic                      buf_flush,
  output logic                      buf_take,
  output logic                      ev_read_done,
  output logic                      ev_buf_issue,
  output logic                      ev_redirect
);
  localparam int INS_W  = OPC_W + ADR_W;
  localparam int WORD_W = 2 * INS_W;

  function automatic logic [INS_W-1:0] left_half(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: INS_W];
  endfunction
  function automatic logic [INS_W-1:0] right_half(input logic [WORD_W-1:0] w);
    return w[INS_W-1:0];
  endfunction
  function automatic logic [OPC_W-1:0] op_of(input logic [INS_W-1:0] i);
    return i[INS_W-1 -: OPC_W];
  endfunction
  function automatic logic [ADR_W-1:0] adr_of(input logic [INS_W-1:0] i);
    return i[ADR_W-1:0];
  endfunction

  fetch_state_e     state;
  logic [OPC_W-1:0] ir;
  logic [ADR_W-1:0] mar;
  logic [WORD_W-1:0] mbr;
  logic             right_only;

  logic accept, take_jump, seq_from_buf, rd_done;
  logic [INS_W-1:0] pick;

  assign accept       = (state == S_ISSUE) && issue_ready;
  assign take_jump    = accept && jump_valid;
  assign seq_from_buf = accept && !jump_valid && buf_valid;
  assign rd_done      = (state == S_READ) && mem_rvalid;
  assign pick         = right_only ? right_half(mbr) : left_half(mbr);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_ADDR;
      ir         <= '0;
      mar        <= '0;
      mbr        <= '0;
      right_only <= 1'b0;
    end else begin
      case (state)
        S_ADDR: begin
          mar   <= pc;
          state <= S_READ;
        end
        S_READ: begin
          if (mem_rvalid) begin
            mbr   <= mem_rdata;
            state <= S_DECODE;
          end
        end
        S_DECODE: begin
          ir         <= op_of(pick);
          mar        <= adr_of(pick);
          right_only <= 1'b0;
          state      <= S_ISSUE;
        end
        default: begin
          if (take_jump) begin
            right_only <= jump_right;
            state      <= S_ADDR;
          end else if (seq_from_buf) begin
            ir  <= op_of(buf_ins);
            mar <= adr_of(buf_ins);
          end else if (accept) begin
            state <= S_ADDR;
          end
        end
      endcase
    end
  end

  assign mem_rd_en    = (state == S_READ);
  assign mem_addr     = mar;
  assign issue_valid  = (state == S_ISSUE);
  assign issue_opcode = ir;
  assign issue_addr   = mar;

  assign pc_load      = take_jump;
  assign pc_load_val  = jump_target;
  assign pc_inc       = rd_done;
  assign buf_park     = (state == S_DECODE) && !right_only;
  assign buf_park_ins = right_half(mbr);
  assign buf_flush    = take_jump;
  assign buf_take     = seq_from_buf;

  assign ev_read_done = rd_done;
  assign ev_buf_issue = seq_from_buf;
  assign ev_redirect  = take_jump;
endmodule

// File: rtl/pair_fetch_unit.sv
module pair_fetch_unit
  import pfu_pkg::*;
#(
  parameter int OPC_W = DEF_OPC_W,
  parameter int ADR_W = DEF_ADR_W
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic                         mem_rd_en,
  output logic [ADR_W-1:0]             mem_addr,
  input  logic [2*(OPC_W+ADR_W)-1:0]   mem_rdata,
  input  logic                         mem_rvalid,
  output logic                         issue_valid,
  output logic [OPC_W-1:0]             issue_opcode,
  output logic [ADR_W-1:0]             issue_addr,
  input  logic                         issue_ready,
  input  logic                         jump_valid,
  input  logic [ADR_W-1:0]             jump_target,
  input  logic                         jump_right
);
  localparam int INS_W = OPC_W + ADR_W;

  logic [ADR_W-1:0] pc, pc_load_val;
  logic             pc_load, pc_inc;
  logic             buf_valid, buf_park, buf_flush, buf_take;
  logic [INS_W-1:0] buf_ins, buf_park_ins;
  logic             ev_read_done, ev_buf_issue, ev_redirect;

  pfu_pc #(.ADR_W(ADR_W)) u_pc (
    .clk(clk), .rst(rst), .load(pc_load), .load_val(pc_load_val),
    .inc(pc_inc), .pc(pc)
  );

  pfu_ibuf #(.INS_W(INS_W)) u_ibuf (
    .clk(clk), .rst(rst), .park(buf_park), .park_ins(buf_park_ins),
    .flush(buf_flush), .take(buf_take), .valid(buf_valid), .ins(buf_ins)
  );

  pfu_seq #(.OPC_W(OPC_W), .ADR_W(ADR_W)) u_seq (
    .clk(clk), .rst(rst), .pc(pc), .buf_valid(buf_valid), .buf_ins(buf_ins),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .issue_ready(issue_ready), .jump_valid(jump_valid),
    .jump_target(jump_target), .jump_right(jump_right),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .issue_valid(issue_valid), .issue_opcode(issue_opcode),
    .issue_addr(issue_addr), .pc_load(pc_load), .pc_load_val(pc_load_val),
    .pc_inc(pc_inc), .buf_park(buf_park), .buf_park_ins(buf_park_ins),
    .buf_flush(buf_flush), .buf_take(buf_take),
    .ev_read_done(ev_read_done), .ev_buf_issue(ev_buf_issue),
    .ev_redirect(ev_redirect)
  );
endmodule

// File: rtl/pair_fetch_unit_chk.sv
module pair_fetch_unit_chk #(
  parameter int OPC_W = 8,
  parameter int ADR_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_rd_en,
  input logic [ADR_W-1:0] mem_addr,
  input logic             mem_rvalid,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic [OPC_W-1:0] issue_opcode,
  input logic [ADR_W-1:0] issue_addr,
  input logic             jump_valid,
  input logic [ADR_W-1:0] jump_target,
  input logic             ev_read_done,
  input logic             ev_buf_issue,
  input logic             ev_redirect
);
  // R1: first cycle out of reset presents nothing
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!issue_valid && !mem_rd_en));

  // R3: read and issue never overlap
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(issue_valid && mem_rd_en));

  // R3: buffered right instruction follows without a memory read
  p_buf_skip_read_r3: assert property (@(posedge clk) disable iff (rst)
    ev_buf_issue |=> (issue_valid && !mem_rd_en));

  // R5: read request held with a stable address until read-valid
  p_read_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && !mem_rvalid) |=> (mem_rd_en && $stable(mem_addr)));

  // R6: jumps arrive only with an acceptance (input contract)
  p_jump_context_r6: assert property (@(posedge clk) disable iff (rst)
    jump_valid |-> (issue_valid && issue_ready));

  // R6: redirected read goes to the jump target two cycles later
  p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
    ev_redirect |=> ##1 (mem_rd_en && (mem_addr == $past(jump_target, 2))));

  // R8: presented instruction is held until accepted
  p_issue_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready) |=>
      (issue_valid && $stable(issue_opcode) && $stable(issue_addr)));

  // R9: first instruction of a read word appears two cycles after read-valid
  p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
    ev_read_done |=> !issue_valid ##1 issue_valid);
endmodule

bind pair_fetch_unit pair_fetch_unit_chk #(.OPC_W(OPC_W), .ADR_W(ADR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .issue_valid(issue_valid),
  .issue_ready(issue_ready), .issue_opcode(issue_opcode),
  .issue_addr(issue_addr), .jump_valid(jump_valid),
  .jump_target(jump_target), .ev_read_done(ev_read_done),
  .ev_buf_issue(ev_buf_issue), .ev_redirect(ev_redirect)
);

// File: tb/pair_fetch_unit_bench.sv
`timescale 1ns/1ps
module pair_fetch_unit_bench;
  logic        clk, rst;
  logic        mem_rd_en, mem_rvalid;
  logic [11:0] mem_addr;
  logic [39:0] mem_rdata;
  logic        issue_valid, issue_ready;
  logic [7:0]  issue_opcode;
  logic [11:0] issue_addr;
  logic        jump_valid, jump_right;
  logic [11:0] jump_target;

  pair_fetch_unit u_pair_fetch_unit (
    .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .issue_valid(issue_valid), .issue_opcode(issue_opcode),
    .issue_addr(issue_addr), .issue_ready(issue_ready),
    .jump_valid(jump_valid), .jump_target(jump_target),
    .jump_right(jump_right)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // reference model state
  logic [19:0] exp_q[$];
  string       tag_q[$];
  int          exp_rd = 0;
  string       rd_tag = "R1";
  bit          right_only_m = 0;
  int          lat = 100, wcnt = 0, n_acc = 0, cyc = 0;
  bit          prev_iv = 0, prev_held = 0, prev_rd = 0;
  logic [7:0]  prev_op;
  logic [11:0] prev_ad, prev_ma;

  function automatic logic [39:0] mem_word(input int a);
    logic [7:0]  lo, ro;
    logic [11:0] la, ra;
    lo = 8'((a * 7 + 3) & 255);
    la = 12'((a * 13 + 5) & 4095);
    ro = 8'((a * 11 + 9) & 255);
    ra = 12'((a + 100) & 4095);
    return {lo, la, ro, ra};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit ready, acc, rv;
    cyc++;
    lat++;
    // compare outputs
    if (mem_rd_en) begin
      chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
      if (prev_rd) chk(mem_addr == prev_ma, "R5", mem_addr, prev_ma);
      chk(int'(mem_addr) == exp_rd, rd_tag, mem_addr, exp_rd);
    end
    if (issue_valid) begin
      if (!prev_iv) chk(lat == 2, "R9", lat, 2);
      if (prev_held) chk({issue_opcode, issue_addr} == {prev_op, prev_ad}, "R8",
                         {issue_opcode, issue_addr}, {prev_op, prev_ad});
      if (exp_q.size() == 0) chk(1'b0, "R3", {issue_opcode, issue_addr}, 0);
      else chk({issue_opcode, issue_addr} == exp_q[0], tag_q[0],
               {issue_opcode, issue_addr}, exp_q[0]);
    end
    // choose next inputs and advance the model
    ready = (cyc % 5) != 2;
    acc = issue_valid && ready;
    issue_ready = ready;
    jump_valid = 1'b0;
    jump_right = 1'b0;
    jump_target = 12'd0;
    if (acc) begin
      int idx;
      idx = n_acc;
      n_acc++;
      if (exp_q.size() > 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (idx % 6 == 4) begin
        jump_valid = 1'b1;
        jump_right = (idx % 12 == 4);
        jump_target = (idx == 10) ? 12'hFFF : 12'((idx * 37 + 1) & 4095);
        exp_q.delete();
        tag_q.delete();
        exp_rd = int'(jump_target);
        rd_tag = jump_right ? "R7" : "R6";
        right_only_m = jump_right;
      end
    end
    rv = 1'b0;
    if (mem_rd_en) begin
      if (wcnt >= int'(mem_addr) % 3) begin
        logic [39:0] w;
        rv = 1'b1;
        w = mem_word(int'(mem_addr));
        mem_rdata = w;
        wcnt = 0;
        lat = 0;
        if (right_only_m) begin
          exp_q.push_back(w[19:0]); tag_q.push_back("R7");
        end else begin
          exp_q.push_back(w[39:20]); tag_q.push_back("R2");
          exp_q.push_back(w[19:0]);  tag_q.push_back("R3");
        end
        right_only_m = 0;
        exp_rd = (int'(mem_addr) + 1) & 4095;
        rd_tag = (mem_addr == 12'hFFF) ? "R10" : "R4";
      end else wcnt++;
    end
    mem_rvalid = rv;
    prev_iv = issue_valid;
    prev_held = issue_valid && !ready;
    prev_op = issue_opcode;
    prev_ad = issue_addr;
    prev_rd = mem_rd_en && !rv;
    prev_ma = mem_addr;
  endtask

  initial begin
    rst = 1'b1;
    mem_rvalid = 1'b0;
    mem_rdata = '0;
    issue_ready = 1'b0;
    jump_valid = 1'b0;
    jump_right = 1'b0;
    jump_target = '0;
    repeat (3) begin
      @(negedge clk);
      chk(!issue_valid && !mem_rd_en, "R1", {issue_valid, mem_rd_en}, 0);
    end
    rst = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      step();
    end
    chk(n_acc > 100, "R2", n_acc, 101);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1: watchdog expired actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule